// File: doc/BRIEF.md
# Bypassable Instruction Queue with Thread-Selective Squash

This block is a short in-order holding queue placed between two pipeline stages. Each instruction is identified by a thread number and a sequence number. A decision command asks whether an instruction may skip the following stage and go directly to the one after it. The skip is granted only if nothing is already queued and the later stage can accept the instruction. A refused instruction is inserted by the next stage and taken out by the stage after that. That removal is a pop of the head, or a targeted removal of a matching entry from any slot.

A squash port flushes the speculative work of one thread. It drops every queued entry of that thread whose sequence number is above a given value. The slots that were flushed are reported as a mask. Survivors close ranks toward the head in the same cycle. A running counter records how many skips were granted.

Command codes on `cmd_op`: 0 decide, 1 insert, 2 remove, 3 pop, 4 to 7 illegal.

Top module: `bypass_iq`

## Requirements
- R1: A decide command (op 0) sets `rsp_bypass`=1 in the response only when the queue is empty, `ds_blocked[cmd_tid]` is 0, and `ds_free` is nonzero. Otherwise `rsp_bypass` is 0. The response appears with `rsp_valid` one cycle after the command.
- R2: `byp_count` increases by exactly one for each granted decide. A refused decide leaves it unchanged.
- R3: An insert (op 1) is appended at the tail with `rsp_ok`=1 only when occupancy, counted after any same-cycle squash, is below DEPTH. Otherwise `rsp_ok`=0 and the queue is unchanged.
- R4: The head outputs show the oldest entry without removing it. A pop (op 3) removes the head with `rsp_ok`=1. A pop on an empty queue returns `rsp_ok`=0.
- R5: A remove (op 2) deletes the first entry whose thread and sequence number both equal `cmd_tid`/`cmd_seq`, from any slot, and returns `rsp_ok`=1. The order of the other entries is preserved. If no entry matches, it returns `rsp_ok`=0.
- R6: A squash deletes every entry with thread equal to `sq_tid` and sequence number strictly greater (unsigned) than `sq_seq`. One cycle later, `flush_mask` bit i is set exactly for the slots i (0 = head) that were deleted.
- R7: Entries of other threads, and entries whose sequence number is at or below `sq_seq`, survive a squash in their original order.
- R8: An insert issued in the same cycle as a squash is dropped, with `rsp_ok`=0, if it meets the squash condition itself.
- R9: An illegal code (4 to 7) raises `err_op` for one cycle, one cycle later. It gives no `rsp_valid` and leaves the queue unchanged.
- R10: After reset the queue is empty (`count`=0, `q_empty`=1, `q_full`=0, `head_valid`=0, `byp_count`=0). `count`, `q_empty` and `q_full` reflect each operation from the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_tid | input | TID_W | Thread of the command's instruction |
| cmd_seq | input | SEQ_W | Sequence number of the command's instruction |
| ds_blocked | input | THREADS | Per-thread stall of the stage two steps ahead |
| ds_free | input | FREE_W | Free input slots of that stage |
| sq_valid | input | 1 | Squash strobe |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Squash boundary sequence number |
| rsp_valid | output | 1 | Response for a legal command |
| rsp_ok | output | 1 | Command succeeded |
| rsp_bypass | output | 1 | Decide result: skip granted |
| err_op | output | 1 | Illegal command code seen |
| flush_mask | output | DEPTH | Slots removed by the last squash |
| head_valid | output | 1 | Head entry present |
| head_tid | output | TID_W | Head thread |
| head_seq | output | SEQ_W | Head sequence number |
| count | output | OCC_W | Occupancy |
| q_empty | output | 1 | Queue empty |
| q_full | output | 1 | Queue full |
| byp_count | output | STAT_W | Granted skips |

## Verification
The assertions assume that `cmd_op` and `cmd_valid` hold settled values at each rising edge. They also assume that `ds_free` describes the stage two steps ahead in the same cycle as the decide. The refused-insert property is checked only in cycles without a squash, because a squash can free room that same cycle. The bench changes every input on the falling edge, and it keeps `cmd_tid` inside the thread range, so `ds_blocked` is always indexed by a real thread.

// File: rtl/bypass_iq.sv
module bypass_iq #(
  parameter int DEPTH   = 4,
  parameter int THREADS = 4,
  parameter int SEQ_W   = 8,
  parameter int FREE_W  = 3,
  parameter int STAT_W  = 16,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [TID_W-1:0]  cmd_tid,
  input  logic [SEQ_W-1:0]  cmd_seq,
  input  logic [THREADS-1:0] ds_blocked,
  input  logic [FREE_W-1:0] ds_free,
  input  logic              sq_valid,
  input  logic [TID_W-1:0]  sq_tid,
  input  logic [SEQ_W-1:0]  sq_seq,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_bypass,
  output logic              err_op,
  output logic [DEPTH-1:0]  flush_mask,
  output logic              head_valid,
  output logic [TID_W-1:0]  head_tid,
  output logic [SEQ_W-1:0]  head_seq,
  output logic [OCC_W-1:0]  count,
  output logic              q_empty,
  output logic              q_full,
  output logic [STAT_W-1:0] byp_count
);

  localparam logic [2:0] OP_DECIDE = 3'd0;
  localparam logic [2:0] OP_INSERT = 3'd1;
  localparam logic [2:0] OP_REMOVE = 3'd2;
  localparam logic [2:0] OP_POP    = 3'd3;

  logic [TID_W-1:0] tid_q [DEPTH];
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [OCC_W-1:0] occ_q;

  logic [TID_W-1:0] tid_d [DEPTH];
  logic [SEQ_W-1:0] seq_d [DEPTH];
  logic [OCC_W-1:0] occ_d;

  logic [DEPTH-1:0] kill, rm_sel, keep;
  logic             rm_found, ins_ok;

  wire is_dec  = cmd_valid && (cmd_op == OP_DECIDE);
  wire is_ins  = cmd_valid && (cmd_op == OP_INSERT);
  wire is_rm   = cmd_valid && (cmd_op == OP_REMOVE);
  wire is_pop  = cmd_valid && (cmd_op == OP_POP);
  wire is_bad  = cmd_valid && cmd_op[2];
  wire do_pop  = is_pop && (occ_q != '0);
  wire grant   = (occ_q == '0) && !ds_blocked[cmd_tid] && (ds_free != '0);
  wire ins_hit = sq_valid && (cmd_tid == sq_tid) && (cmd_seq > sq_seq);

  always_comb begin
    kill     = '0;
    rm_sel   = '0;
    keep     = '0;
    rm_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(occ_q)) begin
        kill[i] = sq_valid && (tid_q[i] == sq_tid) && (seq_q[i] > sq_seq);
        if (is_rm && !rm_found && tid_q[i] == cmd_tid && seq_q[i] == cmd_seq) begin
          rm_sel[i] = 1'b1;
          rm_found  = 1'b1;
        end
        keep[i] = !kill[i] && !rm_sel[i] && !(do_pop && i == 0);
      end
    end
  end

  always_comb begin
    int w;
    w = 0;
    for (int i = 0; i < DEPTH; i++) begin
      tid_d[i] = tid_q[i];
      seq_d[i] = seq_q[i];
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (keep[i]) begin
        tid_d[w] = tid_q[i];
        seq_d[w] = seq_q[i];
        w = w + 1;
      end
    end
    ins_ok = is_ins && !ins_hit && (w < DEPTH);
    if (ins_ok) begin
      tid_d[w] = cmd_tid;
      seq_d[w] = cmd_seq;
      w = w + 1;
    end
    occ_d = OCC_W'(w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q      <= '0;
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_bypass <= 1'b0;
      err_op     <= 1'b0;
      flush_mask <= '0;
      byp_count  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tid_q[i] <= '0;
        seq_q[i] <= '0;
      end
    end else begin
      occ_q <= occ_d;
      for (int i = 0; i < DEPTH; i++) begin
        tid_q[i] <= tid_d[i];
        seq_q[i] <= seq_d[i];
      end
      rsp_valid  <= cmd_valid && !cmd_op[2];
      rsp_bypass <= is_dec && grant;
      rsp_ok     <= (is_dec && grant) || ins_ok || (is_rm && rm_found) || do_pop;
      err_op     <= is_bad;
      flush_mask <= kill;
      if (is_dec && grant) byp_count <= byp_count + STAT_W'(1);
    end
  end

  assign count      = occ_q;
  assign q_empty    = (occ_q == '0);
  assign q_full     = (occ_q == OCC_W'(DEPTH));
  assign head_valid = !q_empty;
  assign head_tid   = tid_q[0];
  assign head_seq   = seq_q[0];

  a_r10_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= OCC_W'(DEPTH));

  a_r1_no_room_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dec && ds_free == '0) |=> (rsp_valid && !rsp_bypass));

  a_r2_busy_keeps_stat: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dec && !q_empty) |=> ($stable(byp_count) && !rsp_bypass));

  a_r3_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ins && q_full && !sq_valid) |=> (rsp_valid && !rsp_ok && q_full));

  a_r4_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pop && !q_empty && !sq_valid) |=> (count == $past(count) - OCC_W'(1)));

  a_r6_head_not_younger: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> !(head_valid && head_tid == $past(sq_tid) && head_seq > $past(sq_seq)));

  a_r9_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
    is_bad |=> (err_op && !rsp_valid && $stable(count)));

endmodule

// File: tb/bypass_iq_bench.sv
module bypass_iq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_tid = '0;
  logic [7:0] cmd_seq = '0;
  logic [3:0] ds_blocked = '0;
  logic [2:0] ds_free = 3'd1;
  logic       sq_valid = 1'b0;
  logic [1:0] sq_tid = '0;
  logic [7:0] sq_seq = '0;
  logic       rsp_valid, rsp_ok, rsp_bypass, err_op, head_valid, q_empty, q_full;
  logic [DEPTH-1:0] flush_mask;
  logic [1:0] head_tid;
  logic [7:0] head_seq;
  logic [2:0] count;
  logic [15:0] byp_count;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bypass_iq u_bypass_iq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_tid(cmd_tid), .cmd_seq(cmd_seq), .ds_blocked(ds_blocked), .ds_free(ds_free),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_bypass(rsp_bypass), .err_op(err_op), .flush_mask(flush_mask),
    .head_valid(head_valid), .head_tid(head_tid), .head_seq(head_seq), .count(count),
    .q_empty(q_empty), .q_full(q_full), .byp_count(byp_count)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(int op, int tid, int seq, bit sqv = 0, int sqt = 0, int sqs = 0);
    @(negedge clk);
    cmd_valid = (op >= 0);
    cmd_op    = 3'(op < 0 ? 0 : op);
    cmd_tid   = 2'(tid);
    cmd_seq   = 8'(seq);
    sq_valid  = sqv;
    sq_tid    = 2'(sqt);
    sq_seq    = 8'(sqs);
    @(negedge clk);
    cmd_valid = 1'b0;
    sq_valid  = 1'b0;
  endtask

  task automatic take_head(string req, int tid, int seq);
    chk({req, " head_valid"}, int'(head_valid), 1);
    chk({req, " head_tid"}, int'(head_tid), tid);
    chk({req, " head_seq"}, int'(head_seq), seq);
    issue(3, 0, 0);
    chk({req, " pop ok"}, int'(rsp_ok), 1);
  endtask

  task automatic t_reset;
    chk("R10 count", int'(count), 0);
    chk("R10 empty", int'(q_empty), 1);
    chk("R10 full", int'(q_full), 0);
    chk("R10 head_valid", int'(head_valid), 0);
    chk("R10 byp_count", int'(byp_count), 0);
  endtask

  task automatic t_bypass;
    issue(0, 1, 20);
    chk("R1 grant", int'(rsp_bypass), 1);
    chk("R2 count one", int'(byp_count), 1);
    ds_blocked = 4'b0010;
    issue(0, 1, 21);
    chk("R1 blocked thread", int'(rsp_bypass), 0);
    chk("R2 unchanged", int'(byp_count), 1);
    issue(0, 2, 22);
    chk("R1 other thread free", int'(rsp_bypass), 1);
    chk("R2 count two", int'(byp_count), 2);
    ds_blocked = '0;
    ds_free = 3'd0;
    issue(0, 0, 23);
    chk("R1 no slot", int'(rsp_bypass), 0);
    chk("R1 rsp_valid", int'(rsp_valid), 1);
    ds_free = 3'd1;
    chk("R10 empty after decides", int'(q_empty), 1);
  endtask

  task automatic t_fill;
    for (int k = 0; k < DEPTH; k++) begin
      issue(1, k, 10 + k);
      chk("R3 insert ok", int'(rsp_ok), 1);
      chk("R10 count", int'(count), k + 1);
    end
    chk("R10 full", int'(q_full), 1);
    issue(1, 0, 14);
    chk("R3 full refused", int'(rsp_ok), 0);
    chk("R3 count kept", int'(count), DEPTH);
    issue(0, 0, 15);
    chk("R1 nonempty refuse", int'(rsp_bypass), 0);
    chk("R2 stat kept", int'(byp_count), 2);
    chk("R4 peek stable", int'(count), DEPTH);
    for (int k = 0; k < DEPTH; k++) take_head("R3 R4 order", k, 10 + k);
    chk("R10 empty", int'(q_empty), 1);
    issue(3, 0, 0);
    chk("R4 pop empty", int'(rsp_ok), 0);
  endtask

  task automatic t_remove;
    issue(1, 0, 1);
    issue(1, 0, 2);
    issue(1, 0, 3);
    issue(2, 0, 2);
    chk("R5 remove middle ok", int'(rsp_ok), 1);
    chk("R5 count", int'(count), 2);
    issue(2, 1, 3);
    chk("R5 no match", int'(rsp_ok), 0);
    chk("R5 count kept", int'(count), 2);
    take_head("R5", 0, 1);
    take_head("R5", 0, 3);
  endtask

  task automatic t_squash;
    issue(1, 0, 5);
    issue(1, 1, 9);
    issue(1, 0, 7);
    issue(1, 0, 4);
    issue(-1, 0, 0, 1, 0, 4);
    chk("R6 flush_mask", int'(flush_mask), 5);
    chk("R6 count", int'(count), 2);
    take_head("R7 other thread", 1, 9);
    take_head("R7 equal seq", 0, 4);
  endtask

  task automatic t_sq_ins;
    issue(1, 1, 2);
    issue(1, 1, 5, 1, 1, 1);
    chk("R8 insert dropped", int'(rsp_ok), 0);
    chk("R8 count", int'(count), 0);
    issue(1, 0, 6);
    issue(1, 1, 8, 1, 0, 0);
    chk("R8 insert kept", int'(rsp_ok), 1);
    chk("R6 flush head", int'(flush_mask), 1);
    take_head("R8", 1, 8);
  endtask

  task automatic t_illegal;
    issue(1, 2, 7);
    issue(5, 2, 7);
    chk("R9 err", int'(err_op), 1);
    chk("R9 no rsp", int'(rsp_valid), 0);
    chk("R9 count kept", int'(count), 1);
    @(negedge clk);
    chk("R9 err clears", int'(err_op), 0);
    take_head("R9", 2, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_fill();
    t_remove();
    t_squash();
    t_sq_ins();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule